// File: doc/BRIEF.md
# Two-Channel Memory-to-Memory Transfer Engine

This block copies a block of words from one memory region to another without processor work. A host programs a source start address, a destination start address and a word count through a small register port, then sets an enable bit. The engine asks a central arbiter for the bus, and once granted it moves each word in two bus cycles: one read from the source address, whose data is caught in an internal holding register, and one write of that held value to the destination address.

Channel 0 always provides the read address and the block length; channel 1 always provides the write address. At the end of a block the engine raises a sticky terminal-count status bit and a one-cycle pulse. With auto-reload selected, both channels' working address and count registers are refilled from their base copies and the next block starts on its own; without it, the engine clears its own enable and stops.

Top module: `dma_xfer_engine`

## Requirements
- R1: A host write to a channel's address register (index 0 for channel 0, index 2 for channel 1) or count register (index 1 for channel 0, index 3 for channel 1) loads both the base and working copy; reading the same index returns the working copy. Index 4 is control (bit 0 enable, bit 1 auto-reload), index 5 is status (bit 0 terminal count).
- R2: Each word is read at channel 0's working address and, in the very next cycle, the read data is written at channel 1's working address.
- R3: After each word both working addresses rise by one and both working counts fall by one (modulo their width); a block is the channel 0 base count plus one words.
- R4: When the channel 0 count steps past zero, status bit 0 becomes 1 and `tc_pulse` is high for exactly one cycle; writing 1 to status bit 0 clears it.
- R5: Without auto-reload, the end of a block clears the enable bit and no further bus cycles follow; channel 0's count then reads all ones and both addresses point one past the block.
- R6: With auto-reload, the end of a block refills working addresses and counts from the base copies, enable stays set, and the next block repeats the same addresses without host access.
- R7: `mem_rd` or `mem_wr` is asserted only while both `bus_req` and `bus_gnt` are high, never both at once.
- R8: `bus_req` stays high from the read through the write of a pair; if the grant is low in the cycle after a write, `bus_req` drops, so with continuous grant it falls once per block and with grant withdrawn after every write it falls once per word.
- R9: After reset all host-visible registers read zero and no bus request or bus cycle is driven.
- R10: Clearing the enable bit mid-block lets at most the pair in progress finish, after which bus activity stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_waddr | input | 3 | Host write register index |
| host_wdata | input | AW | Host write data |
| host_raddr | input | 3 | Host read register index |
| host_rdata | output | AW | Host read data (combinational) |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_addr | output | AW | Memory word address |
| mem_rd | output | 1 | Memory read cycle |
| mem_wr | output | 1 | Memory write cycle |
| mem_wdata | output | DW | Write data from the holding register |
| mem_rdata | input | DW | Read data, valid in the read cycle |
| tc_pulse | output | 1 | One-cycle end-of-block pulse |

## Verification
The assertions take for granted that the arbiter raises the grant only while a request is pending and withdraws it only at the edge that ends a write cycle or when the request is low, and that memory returns read data within the read cycle. The bench's arbiter is a registered model that follows exactly this rule, either holding the grant across a whole block or dropping it after every write, and its memory is a pure function of the address. The host programs the channels only while the engine is idle, which the bench respects by waiting for the terminal count before each reprogramming.

// File: rtl/dma_xfer_pkg.sv
// Shared definitions for the transfer engine: sequencer states and the
// host register index map. Assumes a 3-bit host register index.
package dma_xfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_READ,
        ST_WRITE,
        ST_CHK
    } seq_state_t;

    localparam int REG_IDX_W = 3;

    localparam logic [REG_IDX_W-1:0] RG_SRC_ADDR = 3'd0;
    localparam logic [REG_IDX_W-1:0] RG_SRC_CNT  = 3'd1;
    localparam logic [REG_IDX_W-1:0] RG_DST_ADDR = 3'd2;
    localparam logic [REG_IDX_W-1:0] RG_DST_CNT  = 3'd3;
    localparam logic [REG_IDX_W-1:0] RG_CTRL     = 3'd4;
    localparam logic [REG_IDX_W-1:0] RG_STAT     = 3'd5;

endpackage

// File: rtl/dma_chan_regs.sv
// One channel's address and count: base copies written by the host and
// working copies that step once per word and can be refilled from base.
// Assumes CW <= AW; host load has priority over refill, refill over step.
module dma_chan_regs #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_addr,
    input  logic          ld_cnt,
    input  logic [AW-1:0] ld_data,
    input  logic          step,
    input  logic          reload,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] cur_cnt,
    output logic          at_zero
);

    logic [AW-1:0] base_addr;
    logic [CW-1:0] base_cnt;

    // Address pair: host load, refill from base, or increment per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            cur_addr  <= '0;
        end else if (ld_addr) begin
            base_addr <= ld_data;
            cur_addr  <= ld_data;
        end else if (reload) begin
            cur_addr  <= base_addr;
        end else if (step) begin
            cur_addr  <= cur_addr + 1'b1;
        end
    end

    // Count pair: host load, refill from base, or decrement per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_cnt <= '0;
            cur_cnt  <= '0;
        end else if (ld_cnt) begin
            base_cnt <= ld_data[CW-1:0];
            cur_cnt  <= ld_data[CW-1:0];
        end else if (reload) begin
            cur_cnt  <= base_cnt;
        end else if (step) begin
            cur_cnt  <= cur_cnt - 1'b1;
        end
    end

    assign at_zero = (cur_cnt == '0);

endmodule

// File: rtl/dma_seq.sv
// Bus sequencer: requests the bus, performs a read cycle into the holding
// register and a write cycle from it, then re-checks the grant. Assumes the
// arbiter only withdraws the grant at the end of a write or when idle.
module dma_seq #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          bus_gnt,
    input  logic [DW-1:0] mem_rdata,
    output logic          bus_req,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] hold_q
);

    import dma_xfer_pkg::*;

    seq_state_t st_q, st_d;

    // Next-state selection for the request/read/write/check loop.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:  if (en) st_d = ST_REQ;
            ST_REQ: begin
                if (!en)          st_d = ST_IDLE;
                else if (bus_gnt) st_d = ST_READ;
            end
            ST_READ:  st_d = ST_WRITE;
            ST_WRITE: st_d = ST_CHK;
            ST_CHK:   st_d = (en && bus_gnt) ? ST_READ : ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Holding register: captures the word during the read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)               hold_q <= '0;
        else if (st_q == ST_READ) hold_q <= mem_rdata;
    end

    assign bus_req = (st_q != ST_IDLE);
    assign mem_rd  = (st_q == ST_READ);
    assign mem_wr  = (st_q == ST_WRITE);

endmodule

// File: rtl/dma_host_regs.sv
// Host register port: decodes channel loads, holds control and status,
// detects end of block and produces the refill and pulse, and muxes reads.
// Assumes the host writes channel registers only while the engine is idle.
module dma_host_regs #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [2:0]    host_waddr,
    input  logic          wbit_en,
    input  logic          wbit_auto,
    input  logic [2:0]    host_raddr,
    input  logic          step,
    input  logic          src_zero,
    input  logic [AW-1:0] src_addr,
    input  logic [CW-1:0] src_cnt,
    input  logic [AW-1:0] dst_addr,
    input  logic [CW-1:0] dst_cnt,
    output logic [1:0]    ld_addr,
    output logic [1:0]    ld_cnt,
    output logic          reload,
    output logic          en,
    output logic          tc_pulse,
    output logic [AW-1:0] host_rdata
);

    import dma_xfer_pkg::*;

    logic auto_q;
    logic tc_q;
    logic block_end;
    logic wr_ctrl;
    logic wr_stat;

    assign ld_addr[0] = host_we && (host_waddr == RG_SRC_ADDR);
    assign ld_cnt[0]  = host_we && (host_waddr == RG_SRC_CNT);
    assign ld_addr[1] = host_we && (host_waddr == RG_DST_ADDR);
    assign ld_cnt[1]  = host_we && (host_waddr == RG_DST_CNT);
    assign wr_ctrl    = host_we && (host_waddr == RG_CTRL);
    assign wr_stat    = host_we && (host_waddr == RG_STAT);

    assign block_end  = step && src_zero;
    assign reload     = block_end && auto_q;

    // Control bits: host write wins; a block end without refill disables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= 1'b0;
            auto_q <= 1'b0;
        end else if (wr_ctrl) begin
            en     <= wbit_en;
            auto_q <= wbit_auto;
        end else if (block_end && !auto_q) begin
            en     <= 1'b0;
        end
    end

    // Sticky terminal-count flag with write-one-to-clear, plus the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q     <= 1'b0;
            tc_pulse <= 1'b0;
        end else begin
            tc_pulse <= block_end;
            if (block_end)               tc_q <= 1'b1;
            else if (wr_stat && wbit_en) tc_q <= 1'b0;
        end
    end

    // Read mux over working copies, control and status.
    always_comb begin
        case (host_raddr)
            RG_SRC_ADDR: host_rdata = src_addr;
            RG_SRC_CNT:  host_rdata = AW'(src_cnt);
            RG_DST_ADDR: host_rdata = dst_addr;
            RG_DST_CNT:  host_rdata = AW'(dst_cnt);
            RG_CTRL:     host_rdata = AW'({auto_q, en});
            RG_STAT:     host_rdata = AW'(tc_q);
            default:     host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_xfer_engine.sv
// Top of the memory-to-memory engine: a fixed channel pair (channel 0 reads,
// channel 1 writes), the host register port and the bus sequencer.
// Assumes a single-cycle memory and CW <= AW <= host data width.
module dma_xfer_engine #(
    parameter int AW = 16,
    parameter int CW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [2:0]    host_waddr,
    input  logic [AW-1:0] host_wdata,
    input  logic [2:0]    host_raddr,
    output logic [AW-1:0] host_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          tc_pulse
);

    localparam int NUM_CH = 2;

    logic [AW-1:0] ch_addr [NUM_CH];
    logic [CW-1:0] ch_cnt  [NUM_CH];
    logic [NUM_CH-1:0] ch_zero;
    logic [1:0]    ld_addr;
    logic [1:0]    ld_cnt;
    logic          reload;
    logic          en;
    logic          step;

    assign step = mem_wr;

    // Channel register pairs, one instance per channel of the fixed pair.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dma_chan_regs #(.AW(AW), .CW(CW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_addr  (ld_addr[c]),
            .ld_cnt   (ld_cnt[c]),
            .ld_data  (host_wdata),
            .step     (step),
            .reload   (reload),
            .cur_addr (ch_addr[c]),
            .cur_cnt  (ch_cnt[c]),
            .at_zero  (ch_zero[c])
        );
    end

    dma_host_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_waddr (host_waddr),
        .wbit_en    (host_wdata[0]),
        .wbit_auto  (host_wdata[1]),
        .host_raddr (host_raddr),
        .step       (step),
        .src_zero   (ch_zero[0]),
        .src_addr   (ch_addr[0]),
        .src_cnt    (ch_cnt[0]),
        .dst_addr   (ch_addr[1]),
        .dst_cnt    (ch_cnt[1]),
        .ld_addr    (ld_addr),
        .ld_cnt     (ld_cnt),
        .reload     (reload),
        .en         (en),
        .tc_pulse   (tc_pulse),
        .host_rdata (host_rdata)
    );

    dma_seq #(.DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .bus_gnt   (bus_gnt),
        .mem_rdata (mem_rdata),
        .bus_req   (bus_req),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .hold_q    (mem_wdata)
    );

    // Read cycles use channel 0, write cycles use channel 1.
    assign mem_addr = mem_wr ? ch_addr[1] : ch_addr[0];

    logic unused_zero;
    assign unused_zero = ch_zero[1];

endmodule

// File: rtl/dma_xfer_chk.sv
// Protocol checker for the transfer engine, attached by bind. Assumes the
// arbiter contract described in the brief.
module dma_xfer_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          tc_pulse,
    input logic [DW-1:0] mem_wdata,
    input logic [DW-1:0] mem_rdata
);

    assert_bus_owned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (bus_req && bus_gnt));

    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_pair_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);

    assert_write_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd));

    assert_hold_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_wdata == $past(mem_rdata)));

    assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> bus_req);

    assert_tc_from_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> $past(mem_wr));

    assert_tc_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> !tc_pulse);

endmodule

bind dma_xfer_engine dma_xfer_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .tc_pulse  (tc_pulse),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
);

// File: tb/dma_xfer_engine_tb_top.sv
// Bench: sweeps block lengths 1..8 under two grant patterns, then an
// auto-reload run with a mid-block stop. Memory data is a function of address.
module dma_xfer_engine_tb_top;

    localparam int AW = 16;
    localparam int CW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          host_we;
    logic [2:0]    host_waddr;
    logic [AW-1:0] host_wdata;
    logic [2:0]    host_raddr;
    logic [AW-1:0] host_rdata;
    logic          bus_req;
    logic          bus_gnt;
    logic [AW-1:0] mem_addr;
    logic          mem_rd;
    logic          mem_wr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          tc_pulse;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    dma_xfer_engine #(.AW(AW), .CW(CW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tc_pulse(tc_pulse)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return (a * 16'h0139) ^ 16'h5A3C;
    endfunction

    assign mem_rdata = pat(mem_addr);

    // Arbiter model: grants a pending request; in drop mode withdraws after each write.
    logic drop_mode = 1'b0;
    always @(posedge clk) begin
        if (!rst_n)      bus_gnt <= 1'b0;
        else if (bus_gnt) bus_gnt <= bus_req && !(drop_mode && mem_wr);
        else             bus_gnt <= bus_req;
    end

    // Monitor: checks address/data sequence and counts events.
    int rd_n, wr_n, tc_n, rel_n, bad_n, blk;
    logic [AW-1:0] exp_src, exp_dst;
    bit   mon_on = 1'b0;
    logic req_prev = 1'b0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (mem_rd) begin
                if (mem_addr != exp_src + AW'(rd_n % blk)) bad_n++;
                rd_n++;
            end
            if (mem_wr) begin
                if (mem_addr != exp_dst + AW'(wr_n % blk)) bad_n++;
                if (mem_wdata != pat(exp_src + AW'(wr_n % blk))) bad_n++;
                wr_n++;
            end
            if (tc_pulse) tc_n++;
            if (req_prev && !bus_req) rel_n++;
            req_prev = bus_req;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [2:0] a, input logic [AW-1:0] d);
        @(negedge clk);
        host_we = 1'b1; host_waddr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hr(input logic [2:0] a, output logic [AW-1:0] v);
        @(negedge clk);
        host_raddr = a;
        #1 v = host_rdata;
    endtask

    task automatic mon_start(input logic [AW-1:0] s, input logic [AW-1:0] d, input int b);
        rd_n = 0; wr_n = 0; tc_n = 0; rel_n = 0; bad_n = 0;
        blk = b; exp_src = s; exp_dst = d; req_prev = 1'b0; mon_on = 1'b1;
    endtask

    task automatic wait_tc(input int target);
        for (int i = 0; i < 400 && tc_n < target; i++) @(negedge clk);
    endtask

    task automatic run_block(input logic [AW-1:0] s, input logic [AW-1:0] d,
                             input int n, input logic [CW-1:0] dcnt, input bit drop);
        logic [AW-1:0] v;
        drop_mode = drop;
        hw(3'd0, s);
        hw(3'd1, AW'(n));
        hw(3'd2, d);
        hw(3'd3, AW'(dcnt));
        hr(3'd0, v); chk("R1 src addr readback", 32'(v), 32'(s));
        hr(3'd3, v); chk("R1 dst count readback", 32'(v), 32'(dcnt));
        hw(3'd5, 16'h0001);
        mon_start(s, d, n + 1);
        hw(3'd4, 16'h0001);
        wait_tc(1);
        repeat (6) @(negedge clk);
        mon_on = 1'b0;
        chk("R2 read/write address and data sequence", 32'(bad_n), 32'd0);
        chk("R3 words moved", 32'(wr_n), 32'(n + 1));
        chk("R4 one tc pulse", 32'(tc_n), 32'd1);
        hr(3'd5, v); chk("R4 tc status set", 32'(v), 32'd1);
        hr(3'd4, v); chk("R5 enable self-cleared", 32'(v), 32'd0);
        hr(3'd0, v); chk("R5 src addr past block", 32'(v), 32'(AW'(s + AW'(n + 1))));
        hr(3'd1, v); chk("R5 src count all ones", 32'(v), 32'hFF);
        hr(3'd2, v); chk("R3 dst addr stepped", 32'(v), 32'(AW'(d + AW'(n + 1))));
        hr(3'd3, v); chk("R3 dst count stepped", 32'(v), 32'(CW'(dcnt - CW'(n + 1))));
        chk("R8 request releases", 32'(rel_n), drop ? 32'(n + 1) : 32'd1);
        chk("R7 bus idle after block", 32'({bus_req, mem_rd, mem_wr}), 32'd0);
        hw(3'd5, 16'h0001);
        hr(3'd5, v); chk("R4 tc status cleared by write of 1", 32'(v), 32'd0);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        logic [AW-1:0] v;
        int w1;
        rst_n = 1'b0; host_we = 1'b0; host_waddr = '0; host_wdata = '0; host_raddr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        for (int r = 0; r < 6; r++) begin
            hr(3'(r), v);
            chk("R9 register zero after reset", 32'(v), 32'd0);
        end
        chk("R9 no bus activity after reset", 32'({bus_req, mem_rd, mem_wr, tc_pulse}), 32'd0);

        // Sweep block lengths 1..8 under both grant patterns.
        for (int n = 0; n < 8; n++) begin
            for (int dm = 0; dm < 2; dm++) begin
                run_block(AW'(16'h0010 + n * 5), AW'(16'h0400 + n * 32 + dm * 16),
                          n, CW'(n * 3 + dm + 9), dm[0]);
            end
        end

        // R6 auto-reload: three-word blocks repeat until the host stops them.
        drop_mode = 1'b0;
        hw(3'd0, 16'h0020);
        hw(3'd1, 16'h0002);
        hw(3'd2, 16'h0600);
        hw(3'd3, 16'h0002);
        hw(3'd5, 16'h0001);
        mon_start(16'h0020, 16'h0600, 3);
        hw(3'd4, 16'h0003);
        wait_tc(2);
        hr(3'd4, v); chk("R6 enable kept after block end", 32'(v), 32'd3);
        chk("R6 second block started without host", 32'(tc_n >= 2), 32'd1);
        hw(3'd4, 16'h0000);
        repeat (4) @(negedge clk);
        w1 = wr_n;
        repeat (20) @(negedge clk);
        mon_on = 1'b0;
        chk("R6 repeated block addresses and data", 32'(bad_n), 32'd0);
        chk("R6 at least two full blocks", 32'(wr_n >= 6), 32'd1);
        chk("R10 no writes after stop", 32'(wr_n), 32'(w1));
        chk("R10 bus released after stop", 32'({bus_req, mem_rd, mem_wr}), 32'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule